// File: doc/BRIEF.md
# Software-Triggered Serial Flash Command Sequencer

This block sends one complete serial-flash instruction each time software asks for one. Software fills in a small register set. The command register holds the opcode and the byte counts for the address, dummy, write-data and read-data stages. A separate register holds the flash address, and two 32-bit registers hold up to eight bytes of outgoing data. Software then writes the execute bit and polls a busy flag until the instruction has finished. The bytes the flash returns land in two 32-bit read-back registers.

The serial side is a single-lane bus with an SPI mode-0 clock: the clock idles low, data changes while it is low, and the input is sampled on the rising edge. Each bit takes two system clocks. The sequencer shares the flash with a second access path, which is stubbed here as a read-request input and a write-in-progress input. A triggered command takes the bus away from that path's reads. It waits, however, for a write sequence that is already running to end.

Top module: `flcmd_seq`

## Requirements
- R1: After reset, chip select is high, the serial clock and data output are low, and the read grant is low. The command, read-back-low and read-back-high registers all read as zero.
- R2: The instruction is sent most-significant bit first, in this order: the opcode byte; then the low address bytes, highest of them first, as many as the address count; then the dummy bytes, driven as zero; then the write bytes, taken from byte 0 of the low write register upward; then the read bytes, with the output held at zero.
- R3: An address count above 4 is treated as 4. A write or read count above 8 is treated as 8.
- R4: Read byte i is stored at bits [8i+7:8i] of the 64-bit pair formed by the low register (index 4) and the high register (index 5). Byte positions the command does not fill read as zero.
- R5: Each bit is one low system clock followed by one high system clock, and the clock stays low while chip select is high. Chip select is low for exactly twice as many cycles as there are bits in the instruction, and it rises on the cycle after the last high phase.
- R6: Busy (command bit 25) is set from the edge that captures the execute write until the edge where chip select rises. The execute bit (command bit 24) reads 1 until the command starts and 0 after that.
- R7: While busy, every register write is ignored. No second command is started, and the stored fields and address stay unchanged.
- R8: The read grant is removed at the second clock edge after the execute write is presented. It stays low while chip select is low, and it returns one cycle after chip select rises if the read request is still held.
- R9: While the write-in-progress input is high, a pending command does not start. It starts at the first clock edge at which that input is sampled low.
- R10: Register reads are registered. The data for the index presented before an edge appears after that edge. The register indices are: command 0, address 1, write-low 2, write-high 3, read-low 4, read-high 5. The command register fields are opcode [7:0], address count [10:8], dummy count [15:11], write count [19:16] and read count [23:20].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| ext_rd_req | input | 1 | Read request from the other access path |
| ext_wr_busy | input | 1 | Other path has a write sequence in progress |
| ext_rd_gnt | output | 1 | Grant of the bus to the other path's read |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Register data is due one edge after the index is applied. A command starts one edge after the edge that captures its execute write, unless the other path's write holds it back. Every bit then takes two cycles, and chip select rises one cycle after the last bit. The read grant falls two edges after the execute write is presented and comes back one edge after chip select rises. The bench drives and samples on falling edges and counts edges to each of these points. A flash model clocks in the outgoing bits on the rising serial clock, and its returned bits are fixed before the rising edge on which they are sampled.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;
  localparam int REG_W      = 32;
  localparam int IDX_W      = 3;
  localparam int OPC_W      = 8;
  localparam int NA_W       = 3;
  localparam int ND_W       = 5;
  localparam int NB_W       = 4;
  localparam int MAX_ADDR_B = 4;
  localparam int MAX_DATA_B = 8;
  localparam int BUF_W      = 2 * REG_W;

  localparam logic [IDX_W-1:0] IDX_CMD  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_ADDR = 3'd1;
  localparam logic [IDX_W-1:0] IDX_WLO  = 3'd2;
  localparam logic [IDX_W-1:0] IDX_WHI  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_RLO  = 3'd4;
  localparam logic [IDX_W-1:0] IDX_RHI  = 3'd5;

  typedef enum logic [2:0] {
    SEG_IDLE = 3'd0,
    SEG_OPC  = 3'd1,
    SEG_ADR  = 3'd2,
    SEG_DUM  = 3'd3,
    SEG_WR   = 3'd4,
    SEG_RD   = 3'd5,
    SEG_FIN  = 3'd6
  } seg_e;

  typedef struct packed {
    logic [OPC_W-1:0] opcode;
    logic [NA_W-1:0]  n_addr;
    logic [ND_W-1:0]  n_dummy;
    logic [NB_W-1:0]  n_wr;
    logic [NB_W-1:0]  n_rd;
    logic [REG_W-1:0] addr;
    logic [BUF_W-1:0] wdata;
  } cmd_cfg_t;
endpackage

// File: rtl/flcmd_regs.sv
module flcmd_regs
  import flcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [IDX_W-1:0] reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             accept,
  input  logic             eng_run,
  input  logic [BUF_W-1:0] rd_buf,
  output cmd_cfg_t         cfg,
  output logic             exec_pend,
  output logic             stat_busy,
  output logic [REG_W-1:0] reg_rdata
);
  localparam int F_NA   = OPC_W;
  localparam int F_ND   = F_NA + NA_W;
  localparam int F_NW   = F_ND + ND_W;
  localparam int F_NR   = F_NW + NB_W;
  localparam int F_EXEC = F_NR + NB_W;
  localparam int F_BUSY = F_EXEC + 1;
  localparam int PAD_W  = REG_W - F_BUSY - 1;

  logic [OPC_W-1:0] opc_q;
  logic [NA_W-1:0]  na_q;
  logic [ND_W-1:0]  nd_q;
  logic [NB_W-1:0]  nw_q, nr_q;
  logic [REG_W-1:0] addr_q, wlo_q, whi_q;
  logic [REG_W-1:0] rd_mux;

  assign stat_busy = exec_pend | eng_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      opc_q     <= '0;
      na_q      <= '0;
      nd_q      <= '0;
      nw_q      <= '0;
      nr_q      <= '0;
      addr_q    <= '0;
      wlo_q     <= '0;
      whi_q     <= '0;
      exec_pend <= 1'b0;
    end else begin
      if (accept) exec_pend <= 1'b0;
      if (reg_wr && !stat_busy) begin
        case (reg_addr)
          IDX_CMD: begin
            opc_q     <= reg_wdata[0 +: OPC_W];
            na_q      <= reg_wdata[F_NA +: NA_W];
            nd_q      <= reg_wdata[F_ND +: ND_W];
            nw_q      <= reg_wdata[F_NW +: NB_W];
            nr_q      <= reg_wdata[F_NR +: NB_W];
            exec_pend <= reg_wdata[F_EXEC];
          end
          IDX_ADDR: addr_q <= reg_wdata;
          IDX_WLO:  wlo_q  <= reg_wdata;
          IDX_WHI:  whi_q  <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    cfg.opcode  = opc_q;
    cfg.n_addr  = (int'(na_q) > MAX_ADDR_B) ? NA_W'(MAX_ADDR_B) : na_q;
    cfg.n_dummy = nd_q;
    cfg.n_wr    = (int'(nw_q) > MAX_DATA_B) ? NB_W'(MAX_DATA_B) : nw_q;
    cfg.n_rd    = (int'(nr_q) > MAX_DATA_B) ? NB_W'(MAX_DATA_B) : nr_q;
    cfg.addr    = addr_q;
    cfg.wdata   = {whi_q, wlo_q};
  end

  always_comb begin
    case (reg_addr)
      IDX_CMD:  rd_mux = {{PAD_W{1'b0}}, stat_busy, exec_pend, nr_q, nw_q, nd_q, na_q, opc_q};
      IDX_ADDR: rd_mux = addr_q;
      IDX_WLO:  rd_mux = wlo_q;
      IDX_WHI:  rd_mux = whi_q;
      IDX_RLO:  rd_mux = rd_buf[0 +: REG_W];
      IDX_RHI:  rd_mux = rd_buf[REG_W +: REG_W];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/flcmd_arb.sv
module flcmd_arb (
  input  logic clk,
  input  logic rst,
  input  logic exec_pend,
  input  logic eng_run,
  input  logic ext_rd_req,
  input  logic ext_wr_busy,
  output logic start,
  output logic ext_rd_gnt
);
  assign start = exec_pend & !eng_run & !ext_wr_busy;

  always_ff @(posedge clk) begin
    if (rst) ext_rd_gnt <= 1'b0;
    else     ext_rd_gnt <= ext_rd_req & !ext_wr_busy & !exec_pend & !eng_run;
  end
endmodule

// File: rtl/flcmd_spi.sv
module flcmd_spi
  import flcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  cmd_cfg_t         cfg,
  input  logic             spi_miso,
  output logic             eng_run,
  output logic [BUF_W-1:0] rd_buf,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic             spi_mosi
);
  seg_e             seg_q, nxt_seg, nb_seg;
  logic [ND_W-1:0]  seg_left, nb_left;
  logic [2:0]       bit_idx, wr_idx, rd_idx, nb_widx;
  logic             half;
  logic [7:0]       sh_out, sh_in, nb_byte;

  function automatic logic [ND_W-1:0] seg_len(seg_e s, cmd_cfg_t c);
    case (s)
      SEG_OPC: return ND_W'(1);
      SEG_ADR: return ND_W'(c.n_addr);
      SEG_DUM: return c.n_dummy;
      SEG_WR:  return ND_W'(c.n_wr);
      SEG_RD:  return ND_W'(c.n_rd);
      default: return '0;
    endcase
  endfunction

  function automatic logic [7:0] byte_for(seg_e s, logic [ND_W-1:0] left,
                                          logic [2:0] widx, cmd_cfg_t c);
    logic [1:0] ai;
    ai = 2'(left - ND_W'(1));
    case (s)
      SEG_OPC: return c.opcode;
      SEG_ADR: return 8'(c.addr >> {ai, 3'b000});
      SEG_WR:  return 8'(c.wdata >> {widx, 3'b000});
      default: return 8'h00;
    endcase
  endfunction

  always_comb begin
    nxt_seg = SEG_FIN;
    for (int k = 5; k >= 2; k--) begin
      if (k > int'(seg_q) && seg_len(seg_e'(3'(k)), cfg) != '0)
        nxt_seg = seg_e'(3'(k));
    end
  end

  always_comb begin
    if (seg_left > ND_W'(1)) begin
      nb_seg  = seg_q;
      nb_left = seg_left - ND_W'(1);
    end else begin
      nb_seg  = nxt_seg;
      nb_left = seg_len(nxt_seg, cfg);
    end
    nb_widx = (seg_q == SEG_WR) ? wr_idx + 3'd1 : wr_idx;
    nb_byte = byte_for(nb_seg, nb_left, nb_widx, cfg);
  end

  assign eng_run = (seg_q != SEG_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q    <= SEG_IDLE;
      seg_left <= '0;
      bit_idx  <= '0;
      wr_idx   <= '0;
      rd_idx   <= '0;
      half     <= 1'b0;
      sh_out   <= '0;
      sh_in    <= '0;
      rd_buf   <= '0;
      spi_sclk <= 1'b0;
      spi_cs_n <= 1'b1;
      spi_mosi <= 1'b0;
    end else if (seg_q == SEG_IDLE) begin
      if (start) begin
        seg_q    <= SEG_OPC;
        seg_left <= ND_W'(1);
        bit_idx  <= 3'd7;
        wr_idx   <= '0;
        rd_idx   <= '0;
        half     <= 1'b0;
        sh_out   <= cfg.opcode;
        rd_buf   <= '0;
        spi_cs_n <= 1'b0;
        spi_sclk <= 1'b0;
        spi_mosi <= cfg.opcode[7];
      end
    end else if (!half) begin
      half     <= 1'b1;
      spi_sclk <= 1'b1;
      sh_in    <= {sh_in[6:0], spi_miso};
    end else begin
      half     <= 1'b0;
      spi_sclk <= 1'b0;
      if (bit_idx != 3'd0) begin
        bit_idx  <= bit_idx - 3'd1;
        sh_out   <= {sh_out[6:0], 1'b0};
        spi_mosi <= sh_out[6];
      end else begin
        if (seg_q == SEG_RD) begin
          rd_buf[{rd_idx, 3'b000} +: 8] <= sh_in;
          rd_idx <= rd_idx + 3'd1;
        end
        wr_idx <= nb_widx;
        if (nb_seg == SEG_FIN) begin
          seg_q    <= SEG_IDLE;
          spi_cs_n <= 1'b1;
          spi_mosi <= 1'b0;
        end else begin
          seg_q    <= nb_seg;
          seg_left <= nb_left;
          bit_idx  <= 3'd7;
          sh_out   <= nb_byte;
          spi_mosi <= nb_byte[7];
        end
      end
    end
  end
endmodule

// File: rtl/flcmd_seq.sv
module flcmd_seq
  import flcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [IDX_W-1:0] reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             ext_rd_req,
  input  logic             ext_wr_busy,
  output logic             ext_rd_gnt,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  cmd_cfg_t         cfg;
  logic             exec_pend, stat_busy, eng_run, start;
  logic [BUF_W-1:0] rd_buf;

  flcmd_regs u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .accept(start), .eng_run(eng_run),
    .rd_buf(rd_buf), .cfg(cfg), .exec_pend(exec_pend),
    .stat_busy(stat_busy), .reg_rdata(reg_rdata)
  );

  flcmd_arb u_arb (
    .clk(clk), .rst(rst), .exec_pend(exec_pend), .eng_run(eng_run),
    .ext_rd_req(ext_rd_req), .ext_wr_busy(ext_wr_busy),
    .start(start), .ext_rd_gnt(ext_rd_gnt)
  );

  flcmd_spi u_spi (
    .clk(clk), .rst(rst), .start(start), .cfg(cfg), .spi_miso(spi_miso),
    .eng_run(eng_run), .rd_buf(rd_buf), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
  );
endmodule

// File: rtl/flcmd_seq_chk.sv
module flcmd_seq_chk (
  input logic clk,
  input logic rst,
  input logic spi_cs_n,
  input logic spi_sclk,
  input logic ext_rd_gnt,
  input logic ext_wr_busy,
  input logic stat_busy,
  input logic exec_pend
);
  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);

  p_sclk_alt_r5: assert property (@(posedge clk) disable iff (rst)
    (!spi_cs_n && $past(!spi_cs_n)) |-> (spi_sclk != $past(spi_sclk)));

  p_hold_for_wr_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> !$past(ext_wr_busy));

  p_exec_clr_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> !exec_pend);

  p_busy_cs_r6: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> stat_busy);

  p_gnt_off_r8: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> !ext_rd_gnt);
endmodule

bind flcmd_seq flcmd_seq_chk u_chk (
  .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
  .ext_rd_gnt(ext_rd_gnt), .ext_wr_busy(ext_wr_busy),
  .stat_busy(stat_busy), .exec_pend(exec_pend)
);

// File: tb/tb_flcmd_seq.sv
module tb_flcmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  typedef struct packed {
    logic [7:0]  op;
    logic [2:0]  na;
    logic [4:0]  nd;
    logic [3:0]  nw;
    logic [3:0]  nr;
    logic [31:0] addr;
    logic [31:0] wlo;
    logic [31:0] whi;
    logic [63:0] rs;
    logic [31:0] elo;
    logic [31:0] ehi;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'h9F, 3'd0, 5'd0, 4'd0, 4'd3, 32'h0, 32'h0, 32'h0,
      64'h0000_0000_0018_40EF, 32'h001840EF, 32'h0},
    '{8'h03, 3'd3, 5'd0, 4'd0, 4'd8, 32'h00A1B2C3, 32'h0, 32'h0,
      64'h8877_6655_4433_2211, 32'h44332211, 32'h88776655},
    '{8'h02, 3'd3, 5'd0, 4'd5, 4'd0, 32'h00123456, 32'hDDCCBBAA, 32'h000000EE,
      64'h0, 32'h0, 32'h0},
    '{8'h0B, 3'd4, 5'd1, 4'd0, 4'd2, 32'hCAFEF00D, 32'h0, 32'h0,
      64'h0000_0000_0000_5AA5, 32'h00005AA5, 32'h0},
    '{8'h66, 3'd7, 5'd0, 4'd15, 4'd12, 32'h01020304, 32'h44332211, 32'h88776655,
      64'hF0E0_D0C0_B0A0_9080, 32'hB0A09080, 32'hF0E0D0C0},
    '{8'h06, 3'd0, 5'd0, 4'd0, 4'd0, 32'h0, 32'h0, 32'h0,
      64'h0, 32'h0, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ext_rd_req = 1'b0;
  logic        ext_wr_busy = 1'b0;
  logic        ext_rd_gnt;
  logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  logic         mdl_clr = 1'b0;
  logic [511:0] rx;
  int           nbit;
  int           lead_bits = 0;
  logic [63:0]  rd_stream = '0;
  int           cs_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  flcmd_seq dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_rd_req(ext_rd_req), .ext_wr_busy(ext_wr_busy), .ext_rd_gnt(ext_rd_gnt),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  // flash model: captures outgoing bits on rising serial clock, returns stream bits
  always @(posedge spi_sclk or posedge mdl_clr) begin
    if (mdl_clr) begin
      rx   = '0;
      nbit = 0;
    end else begin
      rx   = {rx[510:0], spi_mosi};
      nbit = nbit + 1;
    end
  end

  always_comb begin
    int k;
    k = nbit - lead_bits;
    if (k >= 0 && k < 64) spi_miso = rd_stream[8*(k/8) + 7 - (k%8)];
    else                  spi_miso = 1'b0;
  end

  always @(posedge clk) begin
    if (mdl_clr)        cs_cnt <= 0;
    else if (!spi_cs_n) cs_cnt <= cs_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic clear_model();
    @(negedge clk); mdl_clr = 1'b1;
    @(negedge clk); mdl_clr = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int t = 0; t < 3000; t++) begin
      reg_read(3'd0, s);
      if (!s[25]) break;
    end
  endtask

  function automatic logic [31:0] cmd_word(input logic [7:0] op, input logic [2:0] na,
      input logic [4:0] nd, input logic [3:0] nw, input logic [3:0] nr, input bit ex);
    return {7'd0, ex, nr, nw, nd, na, op};
  endfunction

  task automatic run_vec(input vec_t v, input int row);
    int na_e, nw_e, nr_e, total;
    logic [511:0] exp;
    logic [63:0]  wd;
    logic [31:0]  lo, hi;
    string        rq;
    na_e = (v.na > 3'd4) ? 4 : int'(v.na);
    nw_e = (v.nw > 4'd8) ? 8 : int'(v.nw);
    nr_e = (v.nr > 4'd8) ? 8 : int'(v.nr);
    total = 1 + na_e + int'(v.nd) + nw_e + nr_e;
    wd = {v.whi, v.wlo};
    exp = '0;
    exp = {exp[503:0], v.op};
    for (int i = na_e - 1; i >= 0; i--) exp = {exp[503:0], 8'(v.addr >> (8*i))};
    for (int i = 0; i < int'(v.nd); i++) exp = {exp[503:0], 8'h00};
    for (int i = 0; i < nw_e; i++) exp = {exp[503:0], 8'(wd >> (8*i))};
    for (int i = 0; i < nr_e; i++) exp = {exp[503:0], 8'h00};
    rq = (row == 4) ? "R3" : "R2";

    reg_write(3'd1, v.addr);
    reg_write(3'd2, v.wlo);
    reg_write(3'd3, v.whi);
    lead_bits = 8 * (1 + na_e + int'(v.nd) + nw_e);
    rd_stream = v.rs;
    clear_model();
    reg_write(3'd0, cmd_word(v.op, v.na, v.nd, v.nw, v.nr, 1'b1));
    wait_idle();

    chk(rx == exp, rq, $sformatf("row %0d serial stream low bits", row),
        rx[63:0], exp[63:0]);
    chk(nbit == 8*total, rq, $sformatf("row %0d bit count", row),
        64'(nbit), 64'(8*total));
    chk(cs_cnt == 16*total, "R5", $sformatf("row %0d chip-select low cycles", row),
        64'(cs_cnt), 64'(16*total));
    reg_read(3'd4, lo);
    reg_read(3'd5, hi);
    chk(lo == v.elo, (row == 4) ? "R3" : "R4", $sformatf("row %0d read-low", row),
        64'(lo), 64'(v.elo));
    chk(hi == v.ehi, (row == 4) ? "R3" : "R4", $sformatf("row %0d read-high", row),
        64'(hi), 64'(v.ehi));
  endtask

  initial begin
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk(spi_cs_n == 1'b1, "R1", "cs_n after reset", 64'(spi_cs_n), 64'(1));
    chk(spi_sclk == 1'b0, "R1", "sclk after reset", 64'(spi_sclk), 64'(0));
    chk(spi_mosi == 1'b0, "R1", "mosi after reset", 64'(spi_mosi), 64'(0));
    chk(ext_rd_gnt == 1'b0, "R1", "grant after reset", 64'(ext_rd_gnt), 64'(0));
    reg_read(3'd0, d); chk(d == 32'h0, "R1", "command reg after reset", 64'(d), 64'(0));
    reg_read(3'd4, d); chk(d == 32'h0, "R1", "read-low after reset", 64'(d), 64'(0));
    reg_read(3'd5, d); chk(d == 32'h0, "R1", "read-high after reset", 64'(d), 64'(0));

    // R10: register read latency
    reg_write(3'd1, 32'h5EED1234);
    reg_read(3'd1, d);
    chk(d == 32'h5EED1234, "R10", "address readback", 64'(d), 64'h5EED1234);
    reg_write(3'd2, 32'hA5A5_0F0F);
    @(negedge clk); reg_addr = 3'd2;
    @(negedge clk);
    chk(reg_rdata == 32'hA5A5_0F0F, "R10", "write-low readback one edge later",
        64'(reg_rdata), 64'hA5A50F0F);

    for (int r = 0; r < NV; r++) run_vec(VECS[r], r);

    // R6 and R7: status bits, writes ignored while busy
    reg_write(3'd1, 32'h00000077);
    lead_bits = 8; rd_stream = 64'h3C;
    clear_model();
    reg_write(3'd0, cmd_word(8'h05, 3'd0, 5'd0, 4'd0, 4'd1, 1'b1));
    repeat (3) @(negedge clk);
    reg_read(3'd0, d);
    chk(d[25] == 1'b1, "R6", "busy while running", 64'(d[25]), 64'(1));
    chk(d[24] == 1'b0, "R6", "execute bit clear once started", 64'(d[24]), 64'(0));
    reg_write(3'd0, cmd_word(8'hAB, 3'd2, 5'd3, 4'd1, 4'd1, 1'b1));
    reg_write(3'd1, 32'hFFFF_FFFF);
    wait_idle();
    repeat (30) @(negedge clk);
    chk(cs_cnt == 32, "R7", "no second command after busy write", 64'(cs_cnt), 64'(32));
    reg_read(3'd0, d);
    chk(d == cmd_word(8'h05, 3'd0, 5'd0, 4'd0, 4'd1, 1'b0), "R7",
        "command fields unchanged", 64'(d), 64'(cmd_word(8'h05, 3'd0, 5'd0, 4'd0, 4'd1, 1'b0)));
    chk(d[25] == 1'b0, "R6", "busy clear after completion", 64'(d[25]), 64'(0));
    reg_read(3'd1, d);
    chk(d == 32'h00000077, "R7", "address unchanged", 64'(d), 64'h77);
    reg_read(3'd4, d);
    chk(d == 32'h0000003C, "R4", "single read byte, rest zero", 64'(d), 64'h3C);

    // R8: pre-emption of the other path's read
    ext_rd_req = 1'b1;
    repeat (2) @(negedge clk);
    chk(ext_rd_gnt == 1'b1, "R8", "grant before command", 64'(ext_rd_gnt), 64'(1));
    reg_write(3'd0, cmd_word(8'h05, 3'd0, 5'd0, 4'd0, 4'd1, 1'b1));
    @(negedge clk);
    chk(ext_rd_gnt == 1'b0, "R8", "grant removed", 64'(ext_rd_gnt), 64'(0));
    chk(spi_cs_n == 1'b0, "R8", "command running", 64'(spi_cs_n), 64'(0));
    for (int t = 0; t < 200 && !spi_cs_n; t++) @(negedge clk);
    chk(ext_rd_gnt == 1'b0, "R8", "grant low as chip select rises", 64'(ext_rd_gnt), 64'(0));
    @(negedge clk);
    chk(ext_rd_gnt == 1'b1, "R8", "grant restored", 64'(ext_rd_gnt), 64'(1));
    ext_rd_req = 1'b0;

    // R9: wait for the other path's write
    ext_wr_busy = 1'b1;
    reg_write(3'd0, cmd_word(8'h05, 3'd0, 5'd0, 4'd0, 4'd1, 1'b1));
    repeat (20) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R9", "held during write", 64'(spi_cs_n), 64'(1));
    reg_read(3'd0, d);
    chk(d[25:24] == 2'b11, "R9", "busy with execute pending", 64'(d[25:24]), 64'(3));
    @(negedge clk); ext_wr_busy = 1'b0;
    @(negedge clk);
    chk(spi_cs_n == 1'b0, "R9", "starts after write ends", 64'(spi_cs_n), 64'(0));
    wait_idle();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end
endmodule